// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Protection

This block keeps a small store of recently used virtual-to-physical page mappings and answers each memory access within the same cycle. An access presents a virtual address, a privilege flag (user or kernel) and a direction flag (read or write). The upper bits of the address form the virtual page number. All stored entries compare this number at once. A matching entry supplies the physical page number, and the block rejoins it to the untouched page offset. Every entry also carries permission bits: readable, writable, user-accessible and dirty.

Each lookup ends in exactly one of three outcomes. A hit returns the physical address, which can go straight to the cache. A miss tells the hardware page walker to fetch the mapping. A protection fault reports an access that the entry's permissions forbid. A write to a clean page counts as a miss, so the walker gets the chance to mark the page dirty in memory.

The walker installs mappings through a refill port. A refill for a page that is already stored replaces that entry. Otherwise the refill takes the lowest-numbered empty slot. When no slot is empty, a first-in first-out pointer picks the victim. A flush input invalidates the whole store in one cycle.

Top module: `tlb_xlat`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's physical page number in bits [31:12] joined with the lookup's offset bits [11:0], in the same cycle as the lookup.
- R2: A lookup whose virtual page number (`lk_vaddr[31:12]`) matches no valid entry gives a miss, with `lk_paddr` equal to zero.
- R3: A lookup that matches an entry faults when any of these holds: user mode and the entry's user bit is clear; a read and the entry's read bit is clear; a write and the entry's write bit is clear. A fault takes priority over the dirty rule in R5.
- R4: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. While it is low, all three are low.
- R5: A permitted write to an entry whose dirty bit is clear gives a miss. The same write hits once the entry is refilled with the dirty bit set. Reads ignore the dirty bit.
- R6: A refill whose virtual page number is already stored overwrites that entry in place, so the store never holds two entries for one page.
- R7: A refill of a new page goes to the lowest-numbered invalid entry. No valid entry is evicted while an invalid one remains, so 32 distinct refills after a flush or reset all stay resident.
- R8: When every entry is valid, a refill of a new page evicts the entry under a pointer. The pointer starts at 0 after reset and then advances by one, wrapping from 31 to 0. It moves only on such evicting refills: refills into empty slots and overwrites leave it unchanged.
- R9: Asserting `flush` invalidates all entries at the next clock edge. A refill in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No usable entry; page walk needed |
| lk_fault | output | 1 | Access denied by entry permissions |
| lk_paddr | output | 32 | Physical address (valid on hit, else zero) |
| rf_valid | input | 1 | Refill request from the walker |
| rf_vpn | input | 20 | Virtual page number being installed |
| rf_ppn | input | 20 | Physical page number being installed |
| rf_user | input | 1 | User-accessible permission of the new entry |
| rf_read | input | 1 | Read permission of the new entry |
| rf_write | input | 1 | Write permission of the new entry |
| rf_dirty | input | 1 | Dirty status of the new entry |

## Verification
The assertions check on every cycle that each lookup produces exactly one outcome, that a hit keeps the page offset, and that no virtual page number matches two entries. They also check that a flush leaves no valid entry and that the replacement pointer holds or steps by exactly one as the refill type dictates. Only the bench's scenarios can show which entry a refill actually displaces. They are also needed to show that the permission combinations give the right outcome, that the dirty rule turns a clean write into a miss, and that the pointer wraps across a full rotation. The bench observes these through later lookups: a translation that should have survived still hits with the right physical page, and an evicted one misses.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    // Per-entry permission and status bits
    typedef struct packed {
        logic usr;   // accessible from user mode
        logic rd;    // readable
        logic wr;    // writable
        logic dty;   // page already marked dirty
    } tlb_perm_t;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_FAULT = 2'd3
    } tlb_out_e;

endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tags,
    input  logic [VPN_W-1:0]                lk_vpn,
    input  logic [VPN_W-1:0]                rf_vpn,
    output logic                            lk_any,
    output logic [IDX_W-1:0]                lk_idx,
    output logic                            rf_any,
    output logic [IDX_W-1:0]                rf_idx,
    output logic                            free_any,
    output logic [IDX_W-1:0]                free_idx
);

    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] rf_vec;

    // One comparator pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_vec[g] = vld[g] && (tags[g] == lk_vpn);
        assign rf_vec[g] = vld[g] && (tags[g] == rf_vpn);
    end

    // Lowest-index encoders
    always_comb begin
        lk_any   = |lk_vec;
        rf_any   = |rf_vec;
        free_any = ~&vld;
        lk_idx   = '0;
        rf_idx   = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_vec[i]) lk_idx = IDX_W'(i);
            if (rf_vec[i]) rf_idx = IDX_W'(i);
            if (!vld[i])   free_idx = IDX_W'(i);
        end
    end

    // R6: refill deduplication upstream keeps every tag unique
    assert_unique_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));
    assert_unique_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rf_vec));

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_go,
    input  logic             rf_any,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic             free_any,
    input  logic [IDX_W-1:0] free_idx,
    output logic [IDX_W-1:0] slot
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } vic_state_t;

    vic_state_t st_d, st_q;
    logic       evict;

    always_comb begin
        st_d  = st_q;
        evict = rf_go && !rf_any && !free_any;
        if (rf_any)        slot = rf_idx;
        else if (free_any) slot = free_idx;
        else               slot = st_q.ptr;
        if (evict) begin
            if (st_q.ptr == IDX_W'(ENTRIES - 1)) st_d.ptr = '0;
            else                                 st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: pointer moves only on evicting refills, by one step with wrap
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_go || rf_any || free_any) |=> $stable(st_q.ptr));
    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_go && !rf_any && !free_any) |=>
            (st_q.ptr == (($past(st_q.ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(st_q.ptr) + 1'b1)));

endmodule

// File: rtl/tlb_perm_chk.sv
`timescale 1ns/1ps
module tlb_perm_chk
    import tlb_pkg::*;
(
    input  logic      req,
    input  logic      found,
    input  tlb_perm_t perm,
    input  logic      is_user,
    input  logic      is_write,
    output tlb_out_e  outcome
);

    logic denied;

    always_comb begin
        denied = (is_user && !perm.usr)
              || (!is_write && !perm.rd)
              || (is_write && !perm.wr);
        if (!req)                         outcome = OUT_NONE;
        else if (!found)                  outcome = OUT_MISS;
        else if (denied)                  outcome = OUT_FAULT;
        else if (is_write && !perm.dty)   outcome = OUT_MISS;
        else                              outcome = OUT_HIT;
    end

endmodule

// File: rtl/tlb_xlat.sv
`timescale 1ns/1ps
module tlb_xlat
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_user,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_user,
    input  logic             rf_read,
    input  logic             rf_write,
    input  logic             rf_dirty
);

    typedef struct packed {
        logic      [ENTRIES-1:0]             vld;
        logic      [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic      [ENTRIES-1:0][PPN_W-1:0]  ppn;
        tlb_perm_t [ENTRIES-1:0]             perm;
    } tlb_state_t;

    tlb_state_t       st_d, st_q;
    logic             lk_any, rf_any, free_any, rf_go;
    logic [IDX_W-1:0] lk_idx, rf_idx, free_idx, slot;
    tlb_out_e         outcome;

    assign rf_go = rf_valid && !flush;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (st_q.vld),
        .tags     (st_q.tag),
        .lk_vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .rf_vpn   (rf_vpn),
        .lk_any   (lk_any),
        .lk_idx   (lk_idx),
        .rf_any   (rf_any),
        .rf_idx   (rf_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .rf_go    (rf_go),
        .rf_any   (rf_any),
        .rf_idx   (rf_idx),
        .free_any (free_any),
        .free_idx (free_idx),
        .slot     (slot)
    );

    tlb_perm_chk i_perm (
        .req      (lk_valid),
        .found    (lk_any),
        .perm     (st_q.perm[lk_idx]),
        .is_user  (lk_user),
        .is_write (lk_write),
        .outcome  (outcome)
    );

    // Next-state: flush wins over refill
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
        end else if (rf_valid) begin
            st_d.vld[slot]      = 1'b1;
            st_d.tag[slot]      = rf_vpn;
            st_d.ppn[slot]      = rf_ppn;
            st_d.perm[slot].usr = rf_user;
            st_d.perm[slot].rd  = rf_read;
            st_d.perm[slot].wr  = rf_write;
            st_d.perm[slot].dty = rf_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lk_hit   = (outcome == OUT_HIT);
        lk_miss  = (outcome == OUT_MISS);
        lk_fault = (outcome == OUT_FAULT);
        lk_paddr = lk_hit ? {st_q.ppn[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
    end

    // R4: one outcome per lookup, none when idle
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
    // R1: offset passes through unchanged
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
    // R2: non-hit outcomes carry a zero address
    assert_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));
    // R9: flush empties the array by the next edge
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0));

endmodule

// File: tb/test_tlb_xlat.sv
`timescale 1ns/1ps
module test_tlb_xlat;

    localparam logic [2:0] E_HIT   = 3'b100;
    localparam logic [2:0] E_MISS  = 3'b010;
    localparam logic [2:0] E_FAULT = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush, lk_valid, lk_user, lk_write;
    logic [31:0] lk_vaddr;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        rf_valid, rf_user, rf_read, rf_write, rf_dirty;
    logic [19:0] rf_vpn, rf_ppn;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [2:0]  kq[$];
    logic [31:0] pq[$];
    string       rq[$];

    always #2.5 clk = ~clk;

    tlb_xlat i_tlb_xlat (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_user(lk_user), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_user(rf_user), .rf_read(rf_read), .rf_write(rf_write), .rf_dirty(rf_dirty)
    );

    function automatic logic [19:0] map_of(logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        flush = 0; lk_valid = 0; lk_vaddr = '0; lk_user = 0; lk_write = 0;
        rf_valid = 0; rf_vpn = '0; rf_ppn = '0;
        rf_user = 0; rf_read = 0; rf_write = 0; rf_dirty = 0;
    endtask

    task automatic refill(logic [19:0] vpn, logic [19:0] ppn,
                          bit u, bit r, bit w, bit d, bit fl);
        @(negedge clk);
        clr();
        rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn;
        rf_user = u; rf_read = r; rf_write = w; rf_dirty = d;
        flush = fl;
    endtask

    // Driver: applies a lookup and queues the expected outcome
    task automatic look(logic [19:0] vpn, logic [11:0] off, bit user, bit wr,
                        logic [2:0] exp, logic [19:0] ppn, string req);
        @(negedge clk);
        clr();
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_user = user; lk_write = wr;
        kq.push_back(exp);
        pq.push_back((exp == E_HIT) ? {ppn, off} : 32'h0);
        rq.push_back(req);
    endtask

    // Monitor: pops expected items and compares once outputs settle
    always @(negedge clk) begin
        #1;
        if (lk_valid && rst_n) begin
            if (kq.size() == 0) begin
                check(0, "R4 unexpected lookup", 36'h0, 36'h0);
            end else begin
                logic [2:0]  ek;
                logic [31:0] ep;
                string       er;
                ek = kq.pop_front();
                ep = pq.pop_front();
                er = rq.pop_front();
                check({lk_hit, lk_miss, lk_fault} == ek, er,
                      {33'h0, lk_hit, lk_miss, lk_fault}, {33'h0, ek});
                check(lk_paddr == ep, er, {4'h0, lk_paddr}, {4'h0, ep});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R4: idle outputs quiet in reset
        check({lk_hit, lk_miss, lk_fault} == 3'b000 && lk_paddr == 0, "R4 reset idle",
              {1'b0, lk_hit, lk_miss, lk_fault, lk_paddr}, 36'h0);
        rst_n = 1;

        // R2: empty array misses
        look(20'h00100, 12'h abc, 0, 0, E_MISS, 0, "R2 empty miss");

        // R1: full-permission page
        refill(20'h00100, map_of(20'h00100), 1, 1, 1, 1, 0);
        look(20'h00100, 12'h3c4, 1, 0, E_HIT, map_of(20'h00100), "R1 user read hit");
        look(20'h00100, 12'hfff, 0, 1, E_HIT, map_of(20'h00100), "R1 kernel write hit");
        look(20'h00101, 12'h000, 0, 0, E_MISS, 0, "R2 neighbour miss");

        // R3: kernel-only, read-only page
        refill(20'h00200, map_of(20'h00200), 0, 1, 0, 0, 0);
        look(20'h00200, 12'h010, 1, 0, E_FAULT, 0, "R3 user on kernel page");
        look(20'h00200, 12'h010, 0, 0, E_HIT, map_of(20'h00200), "R3 kernel read ok");
        look(20'h00200, 12'h010, 0, 1, E_FAULT, 0, "R3 write to read-only beats dirty");
        // R3: write-only page, read faults
        refill(20'h00400, map_of(20'h00400), 1, 0, 1, 1, 0);
        look(20'h00400, 12'h020, 1, 0, E_FAULT, 0, "R3 read without read bit");
        look(20'h00400, 12'h020, 1, 1, E_HIT, map_of(20'h00400), "R3 write allowed");

        // R5: clean writable page
        refill(20'h00300, map_of(20'h00300), 1, 1, 1, 0, 0);
        look(20'h00300, 12'h044, 1, 1, E_MISS, 0, "R5 clean write miss");
        look(20'h00300, 12'h044, 1, 0, E_HIT, map_of(20'h00300), "R5 clean read hit");
        // R6: overwrite in place with dirty set and new frame
        refill(20'h00300, 20'h0BEEF, 1, 1, 1, 1, 0);
        look(20'h00300, 12'h044, 1, 1, E_HIT, 20'h0BEEF, "R5 R6 dirty write hit new frame");

        // R9: flush beats same-cycle refill
        refill(20'h00500, map_of(20'h00500), 1, 1, 1, 1, 1);
        look(20'h00500, 12'h0, 0, 0, E_MISS, 0, "R9 refill dropped by flush");
        look(20'h00100, 12'h0, 0, 0, E_MISS, 0, "R9 old entry flushed");
        look(20'h00300, 12'h0, 0, 0, E_MISS, 0, "R9 second entry flushed");

        // R6/R7: duplicate refill then fill remaining 31 slots
        refill(20'h01000, 20'h11111, 1, 1, 1, 1, 0);
        refill(20'h01000, 20'h12345, 1, 1, 1, 1, 0);
        for (int i = 1; i < 32; i++)
            refill(20'h01000 + 20'(i), map_of(20'h01000 + 20'(i)), 1, 1, 1, 1, 0);
        look(20'h01000, 12'h008, 0, 0, E_HIT, 20'h12345, "R6 overwritten entry resident");
        for (int i = 1; i < 32; i++)
            look(20'h01000 + 20'(i), 12'(i), 0, 0, E_HIT, map_of(20'h01000 + 20'(i)),
                 "R7 all 32 resident");

        // R8: first eviction hits slot 0
        refill(20'h02000, map_of(20'h02000), 1, 1, 1, 1, 0);
        look(20'h01000, 12'h0, 0, 0, E_MISS, 0, "R8 oldest evicted");
        look(20'h01001, 12'h0, 0, 0, E_HIT, map_of(20'h01001), "R8 next survives");
        look(20'h02000, 12'h5, 0, 0, E_HIT, map_of(20'h02000), "R8 new entry present");
        // R8: overwrite in a full array does not move the pointer
        refill(20'h01005, 20'h0AAAA, 1, 1, 1, 1, 0);
        refill(20'h02001, map_of(20'h02001), 1, 1, 1, 1, 0);
        look(20'h01001, 12'h0, 0, 0, E_MISS, 0, "R8 slot 1 evicted after overwrite");
        look(20'h01002, 12'h0, 0, 0, E_HIT, map_of(20'h01002), "R8 slot 2 survives");
        look(20'h01005, 12'h0, 0, 0, E_HIT, 20'h0AAAA, "R8 overwritten entry kept");
        // R8: walk pointer through slots 2..31, then wrap to 0
        for (int k = 0; k < 30; k++)
            refill(20'h03000 + 20'(k), map_of(20'h03000 + 20'(k)), 1, 1, 1, 1, 0);
        look(20'h02000, 12'h0, 0, 0, E_HIT, map_of(20'h02000), "R8 slot 0 before wrap");
        refill(20'h04000, map_of(20'h04000), 1, 1, 1, 1, 0);
        look(20'h02000, 12'h0, 0, 0, E_MISS, 0, "R8 wrap evicts slot 0");
        look(20'h02001, 12'h0, 0, 0, E_HIT, map_of(20'h02001), "R8 slot 1 after wrap");
        look(20'h0301D, 12'h0, 0, 0, E_HIT, map_of(20'h0301D), "R8 slot 31 kept");
        look(20'h04000, 12'h7, 1, 0, E_HIT, map_of(20'h04000), "R8 wrapped entry");

        @(negedge clk);
        clr();
        repeat (2) @(negedge clk);
        check(kq.size() == 0, "R4 all lookups answered", 36'(kq.size()), 36'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule